// File: doc/BRIEF.md
# Age-Ordered Instruction Holding Station

This block holds decoded instructions for an out-of-order core until the issue stage takes them. Every slot lives in a single storage array that never moves data. Two singly linked lists run through that array. The occupied list keeps the waiting instructions in arrival order. The free list keeps the idle slots. An accepted instruction takes the first free slot, receives its payload there and is linked onto the young end of the occupied list. An issued instruction leaves from the old end of the occupied list, and its slot is linked onto the free list. Both lists, including their head, tail and length registers, are rewritten in the same clock.

Instructions enter through a valid/ready stream: a payload is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the producer must hold its payload, and nothing is taken. `in_ready` depends only on registered state, so there is no combinational path from `out_ready` to `in_ready`. Instructions leave through a second valid/ready stream that always offers the oldest waiting instruction. The offered payload stays fixed until issue takes it by raising `out_ready`. The payload is a tag plus opaque microcode bits, and the block never interprets either one.

Top module: `age_link_station`

## Requirements
- R1: After reset, the station is empty: `occupancy` = 0, `out_valid` = 0 and `in_ready` = 1.
- R2: `in_ready` is 0 exactly when `occupancy` equals DEPTH. An instruction is taken only on a clock edge with `in_valid` = 1 and `in_ready` = 1. An `in_valid` that arrives while `in_ready` is 0 leaves the stored contents unchanged.
- R3: `out_valid` is 1 exactly when `occupancy` is nonzero. While `out_valid` = 1 and `out_ready` = 0, `out_tag` and `out_uc` stay unchanged.
- R4: Instructions leave in the order they were taken. `out_tag` and `out_uc` always show the oldest instruction still held.
- R5: An accepted instruction changes `occupancy` on the next clock. If the station was empty, the instruction is offered on the outputs in that same next cycle.
- R6: When an insert and a remove happen on the same edge, `occupancy` stays the same and both take effect. This includes the case where exactly one instruction was held, in which the new instruction becomes the offered one.
- R7: When the station is full, a remove does not make room for an insert on the same edge. `in_ready` stays 0 during that cycle and returns to 1 on the next cycle.
- R8: `occupancy` always equals the length of the occupied list. The two list lengths always add up to DEPTH. Every slot is on exactly one list, with no slot missing and none repeated.
- R9: Slots are reused without limit. Any number of operations past DEPTH keeps R4 and R8 true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers an instruction |
| in_ready | output | 1 | A free slot exists this cycle |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_uc | input | UC_W | Microcode bits of the offered instruction |
| out_valid | output | 1 | An instruction is offered to issue |
| out_ready | input | 1 | Issue takes the offered instruction |
| out_tag | output | TAG_W | Tag of the oldest held instruction |
| out_uc | output | UC_W | Microcode bits of the oldest held instruction |
| occupancy | output | $clog2(DEPTH+1) | Number of held instructions |

## Verification
Assertions check several properties on every cycle. They walk both linked lists and confirm that the lists split the array with no slot missing or repeated. They confirm that the two lengths add up to DEPTH and that the count moves by exactly push minus pop. They check that a stalled offer holds steady, and that a full station frees its input only on the cycle after a remove. Other properties can only be shown by the bench scenarios, which compare against a reference queue: true age ordering across many slot reuses, correct payload contents, the simultaneous insert and remove with a single held instruction, and the rejection of an insert while full.

// File: rtl/als_pkg.sv
package als_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_REM  = 2'b01,
    OP_INS  = 2'b10,
    OP_BOTH = 2'b11
  } link_op_e;
endpackage

// File: rtl/als_payload_store.sv
module als_payload_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 22,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  // Payload is written once on insert and never moved afterwards.
  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/als_link_ctrl.sv
module als_link_ctrl
  import als_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] ins_idx,
  output logic [IDX_W-1:0] rem_idx,
  output logic [CNT_W-1:0] used_cnt,
  output logic [CNT_W-1:0] free_cnt
);
  logic [IDX_W-1:0] nxt_q [DEPTH];
  logic [IDX_W-1:0] u_head_q, u_tail_q, f_head_q, f_tail_q;
  logic [CNT_W-1:0] u_cnt_q, f_cnt_q;
  link_op_e         op;

  assign op       = link_op_e'({push, pop});
  assign ins_idx  = f_head_q;
  assign rem_idx  = u_head_q;
  assign used_cnt = u_cnt_q;
  assign free_cnt = f_cnt_q;

  // A list becomes empty (before the append) when its only entry leaves this cycle.
  logic used_drains, free_drains;
  assign used_drains = (u_cnt_q == '0) || (pop  && u_cnt_q == CNT_W'(1));
  assign free_drains = (f_cnt_q == '0) || (push && f_cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) nxt_q[i] <= IDX_W'((i + 1) % DEPTH);
      u_head_q <= '0;
      u_tail_q <= '0;
      u_cnt_q  <= '0;
      f_head_q <= '0;
      f_tail_q <= IDX_W'(DEPTH - 1);
      f_cnt_q  <= CNT_W'(DEPTH);
    end else begin
      case (op)
        OP_INS: begin
          f_head_q <= nxt_q[f_head_q];
          if (used_drains) u_head_q <= f_head_q;
          else             nxt_q[u_tail_q] <= f_head_q;
          u_tail_q <= f_head_q;
          u_cnt_q  <= u_cnt_q + CNT_W'(1);
          f_cnt_q  <= f_cnt_q - CNT_W'(1);
        end
        OP_REM: begin
          u_head_q <= nxt_q[u_head_q];
          if (free_drains) f_head_q <= u_head_q;
          else             nxt_q[f_tail_q] <= u_head_q;
          f_tail_q <= u_head_q;
          u_cnt_q  <= u_cnt_q - CNT_W'(1);
          f_cnt_q  <= f_cnt_q + CNT_W'(1);
        end
        OP_BOTH: begin
          // Used side: old head leaves, free head joins at the tail.
          if (used_drains) u_head_q <= f_head_q;
          else begin
            u_head_q        <= nxt_q[u_head_q];
            nxt_q[u_tail_q] <= f_head_q;
          end
          u_tail_q <= f_head_q;
          // Free side: free head leaves, old used head joins at the tail.
          if (free_drains) f_head_q <= u_head_q;
          else begin
            f_head_q        <= nxt_q[f_head_q];
            nxt_q[f_tail_q] <= u_head_q;
          end
          f_tail_q <= u_head_q;
        end
        default: ;
      endcase
    end
  end

  // Checking only: walk both lists and mark which slots each one reaches.
  logic [DEPTH-1:0] on_used, on_free;
  logic             walk_dup;
  always_comb begin
    logic [IDX_W-1:0] pu, pf;
    on_used  = '0;
    on_free  = '0;
    walk_dup = 1'b0;
    pu = u_head_q;
    pf = f_head_q;
    for (int k = 0; k < DEPTH; k++) begin
      if (CNT_W'(k) < u_cnt_q) begin
        if (on_used[pu]) walk_dup = 1'b1;
        on_used[pu] = 1'b1;
        pu = nxt_q[pu];
      end
      if (CNT_W'(k) < f_cnt_q) begin
        if (on_free[pf]) walk_dup = 1'b1;
        on_free[pf] = 1'b1;
        pf = nxt_q[pf];
      end
    end
  end

  a_r8_lengths_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (u_cnt_q + f_cnt_q) == CNT_W'(DEPTH));

  a_r8_lists_partition: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_dup && ((on_used & on_free) == '0) && ((on_used | on_free) == '1));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> u_cnt_q == $past(u_cnt_q) + CNT_W'($past(push)) - CNT_W'($past(pop)));

  a_r9_tail_joins: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> u_tail_q == $past(f_head_q));
endmodule

// File: rtl/age_link_station.sv
module age_link_station #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int UC_W  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = TAG_W + UC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [UC_W-1:0]  in_uc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TAG_W-1:0] out_tag,
  output logic [UC_W-1:0]  out_uc,
  output logic [CNT_W-1:0] occupancy
);
  logic             push, pop;
  logic [IDX_W-1:0] ins_idx, rem_idx;
  logic [CNT_W-1:0] used_cnt, free_cnt;
  logic [DATA_W-1:0] rd_word;

  assign in_ready  = (free_cnt != '0);
  assign out_valid = (used_cnt != '0);
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign occupancy = used_cnt;
  assign {out_tag, out_uc} = rd_word;

  als_link_ctrl #(.DEPTH(DEPTH)) i_links (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .ins_idx  (ins_idx),
    .rem_idx  (rem_idx),
    .used_cnt (used_cnt),
    .free_cnt (free_cnt)
  );

  als_payload_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk     (clk),
    .wr_en   (push),
    .wr_idx  (ins_idx),
    .wr_data ({in_tag, in_uc}),
    .rd_idx  (rem_idx),
    .rd_data (rd_word)
  );

  a_r3_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_tag) && $stable(out_uc));

  a_r7_full_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && pop) |=> in_ready);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pop) |=> !in_ready && occupancy == CNT_W'(DEPTH));

  a_r5_first_offered: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && push) |=> out_valid && out_tag == $past(in_tag));
endmodule

// File: tb/test_age_link_station.sv
module test_age_link_station;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;
  localparam int UC_W  = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [UC_W-1:0]  in_uc = '0;
  logic in_ready, out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [UC_W-1:0]  out_uc;
  logic [CNT_W-1:0] occupancy;

  always #5 clk = ~clk;

  age_link_station #(.DEPTH(DEPTH), .TAG_W(TAG_W), .UC_W(UC_W)) i_age_link_station (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_uc(in_uc), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_uc(out_uc), .occupancy(occupancy)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Reference queue
  logic [TAG_W+UC_W-1:0] ref_q [64];
  int ref_rd = 0, ref_wr = 0, ref_cnt = 0;
  logic [TAG_W-1:0] tag_seq = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Checks outputs against the model at the negative edge, then applies one clock.
  task automatic step(input bit iv, input bit ordy, input string req);
    bit exp_push, exp_pop;
    in_valid  = iv;
    in_tag    = tag_seq;
    in_uc     = lfsr;
    out_ready = ordy;
    #1;
    check(occupancy == CNT_W'(ref_cnt), {req, " occupancy"}, occupancy, ref_cnt);
    check(in_ready == (ref_cnt < DEPTH), {req, " in_ready"}, in_ready, ref_cnt < DEPTH);
    check(out_valid == (ref_cnt > 0), {req, " out_valid"}, out_valid, ref_cnt > 0);
    if (ref_cnt > 0)
      check({out_tag, out_uc} == ref_q[ref_rd % 64], {req, " R4 oldest"},
            {out_tag, out_uc}, ref_q[ref_rd % 64]);
    exp_push = iv && (ref_cnt < DEPTH);
    exp_pop  = ordy && (ref_cnt > 0);
    @(posedge clk);
    if (exp_pop) begin ref_rd++; ref_cnt--; end
    if (exp_push) begin
      ref_q[ref_wr % 64] = {tag_seq, lfsr};
      ref_wr++; ref_cnt++;
    end
    if (iv) tag_seq = tag_seq + 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    check(occupancy == 0, "R1 occupancy", occupancy, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
  endtask

  task automatic t_fill_drain;
    for (int i = 0; i < DEPTH; i++) step(1, 0, "R5 fill");
    // Full: offered inserts must be ignored (R2)
    for (int i = 0; i < 3; i++) step(1, 0, "R2 full ignore");
    for (int i = 0; i < DEPTH; i++) step(0, 1, "R4 drain");
    step(0, 0, "R1 empty again");
  endtask

  task automatic t_stall;
    step(1, 0, "R5 one");
    step(1, 0, "R5 two");
    for (int i = 0; i < 4; i++) step(0, 0, "R3 stall hold");
    step(0, 1, "R3 release");
    step(0, 1, "R3 release");
    step(0, 0, "R3 empty");
  endtask

  task automatic t_single_swap;
    step(1, 0, "R6 prime");
    step(1, 1, "R6 swap single");
    step(1, 1, "R6 swap single again");
    step(0, 1, "R6 drain");
    step(0, 0, "R6 empty");
  endtask

  task automatic t_full_swap;
    for (int i = 0; i < DEPTH; i++) step(1, 0, "R7 fill");
    step(1, 1, "R7 remove on full");
    #1;
    check(in_ready == 1'b1, "R7 reopened", in_ready, 1);
    check(occupancy == CNT_W'(DEPTH - 1), "R7 not refilled", occupancy, DEPTH - 1);
    step(1, 1, "R7 swap after");
    for (int i = 0; i < DEPTH; i++) step(0, 1, "R7 drain");
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 400; i++) step(lfsr[3] | lfsr[7], lfsr[1] ^ lfsr[9], "R9 mixed");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, "R8 final drain");
    check(occupancy == 0, "R8 empty end", occupancy, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_stall();
    t_single_swap();
    t_full_swap();
    t_mixed();
    summary();
    $finish;
  end
endmodule